// File: doc/BRIEF.md
# Doublescan Low-Resolution Raster Timing Generator

This block sequences the raster for a 320 by 200 picture shown on a VGA-class monitor. A line is 416 pixel clocks long. The frame counts 222 logical rows, and each logical row is scanned twice, so the monitor receives 444 physical lines per frame. With a 15.75 MHz dot clock the refresh rate comes out near 85 Hz.

The block drives horizontal and vertical sync, a display-enable, the current pixel column, the logical row, a flag that marks the second (repeated) scan of a row, and a one-clock end-of-frame strobe. A pixel source reads `col` and `row` and places data on the screen whenever `de` is high.

All outputs are registers. The syncs, enable and strobe are decoded from the counters' next-state values. Because of this they line up exactly with the `col`/`row`/`rescan` values shown in the same cycle, and they cannot glitch. The vertical front porch is zero, so vertical sync begins on the first scan of the row after the last visible row. There is no data stream at the edge of the block, so no valid/ready handshake is present. All pins are plain control and status signals.

Top module: `dblscan_timing`

## Requirements
- R1: `col` advances by one on every clock and wraps from 415 back to 0.
- R2: `rescan` is 0 on the first scan of a row and 1 on the second scan. It toggles at every column wrap. `row` advances only at a column wrap while `rescan` is 1, and it wraps from 221 back to 0.
- R3: `de` is 1 exactly when `col` < 320 and `row` < 200, in the same cycle as those counter values.
- R4: `hsync` is at its active level (0 by default) exactly when 336 <= `col` <= 367, and at 1 at all other times.
- R5: `vsync` is at its active level (0 by default) exactly when `row` is 200 or 201, on both scans of each of those rows. It therefore starts on the cycle right after column 415 of the second scan of row 199.
- R6: `frame_end` is 1 for exactly one clock per frame, when `col` = 415, `row` = 221 and `rescan` = 1.
- R7: On the clock after `rst` is sampled high, the outputs are `col` = 0, `row` = 0, `rescan` = 0, `de` = 1, and both syncs are inactive.
- R8: Parameter `SYNC_ACT_LOW` selects the sync polarity. With the default value of 1 the syncs are active-low. With 0 the syncs are active-high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| hsync | output | 1 | Horizontal sync, registered |
| vsync | output | 1 | Vertical sync, registered |
| de | output | 1 | Display enable, registered |
| col | output | 9 | Pixel column, 0..415 |
| row | output | 8 | Logical row, 0..221 |
| rescan | output | 1 | 1 on the repeated scan of a row |
| frame_end | output | 1 | One-clock strobe on the last pixel of the frame |

## Verification
Every output belongs to the same cycle as the counter values it describes, so no lag has to be accounted for. A reset sampled at one rising edge shows its effect on the outputs right after that edge.

The bench advances a software model of the column, row and scan counters at each rising edge. On the following falling edge it compares all nine outputs against values computed arithmetically from that model.

The bench sweeps one complete 416 by 444 clock frame after a mid-frame reset. This sweep covers every sync boundary and the zero-porch transition into vertical sync. It also counts the end-of-frame strobes seen across the frame.

// File: rtl/dblscan_pkg.sv
package dblscan_pkg;
  // Convert an "asserted" condition into the pin level for the chosen polarity.
  function automatic logic sync_level(input logic asserted, input bit act_low);
    return act_low ? ~asserted : asserted;
  endfunction
endpackage

// File: rtl/dbs_hcount.sv
module dbs_hcount #(
  parameter int H_TOTAL = 416,
  parameter int CW      = 9
) (
  input  logic          clk,
  input  logic          rst,
  output logic [CW-1:0] col_q,
  output logic [CW-1:0] col_n,
  output logic          line_last
);
  assign line_last = (col_q == CW'(H_TOTAL - 1));

  always_comb begin
    if (rst)            col_n = '0;
    else if (line_last) col_n = '0;
    else                col_n = col_q + 1'b1;
  end

  always_ff @(posedge clk) col_q <= col_n;
endmodule

// File: rtl/dbs_vcount.sv
module dbs_vcount #(
  parameter int V_TOTAL = 222,
  parameter int RW      = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          line_last,
  output logic          scan_q,
  output logic [RW-1:0] row_q,
  output logic          scan_n,
  output logic [RW-1:0] row_n
);
  logic row_last;
  assign row_last = (row_q == RW'(V_TOTAL - 1));

  always_comb begin
    scan_n = scan_q;
    row_n  = row_q;
    if (rst) begin
      scan_n = 1'b0;
      row_n  = '0;
    end else if (line_last) begin
      scan_n = ~scan_q;
      if (scan_q) row_n = row_last ? '0 : row_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    scan_q <= scan_n;
    row_q  <= row_n;
  end
endmodule

// File: rtl/dbs_decode.sv
module dbs_decode
  import dblscan_pkg::*;
#(
  parameter int H_ACTIVE = 320,
  parameter int H_SYNC_B = 336,
  parameter int H_SYNC_E = 368,
  parameter int H_TOTAL  = 416,
  parameter int V_ACTIVE = 200,
  parameter int V_SYNC_B = 200,
  parameter int V_SYNC_E = 202,
  parameter int V_TOTAL  = 222,
  parameter int CW       = 9,
  parameter int RW       = 8,
  parameter bit ACT_LOW  = 1'b1
) (
  input  logic          clk,
  input  logic [CW-1:0] col_n,
  input  logic [RW-1:0] row_n,
  input  logic          scan_n,
  output logic          hsync,
  output logic          vsync,
  output logic          de,
  output logic          frame_end
);
  logic h_on, v_on, de_n, fe_n;

  always_comb begin
    h_on = (col_n >= CW'(H_SYNC_B)) && (col_n < CW'(H_SYNC_E));
    v_on = (row_n >= RW'(V_SYNC_B)) && (row_n < RW'(V_SYNC_E));
    de_n = (col_n < CW'(H_ACTIVE)) && (row_n < RW'(V_ACTIVE));
    fe_n = (col_n == CW'(H_TOTAL - 1)) && (row_n == RW'(V_TOTAL - 1)) && scan_n;
  end

  always_ff @(posedge clk) begin
    hsync     <= sync_level(h_on, ACT_LOW);
    vsync     <= sync_level(v_on, ACT_LOW);
    de        <= de_n;
    frame_end <= fe_n;
  end
endmodule

// File: rtl/dblscan_timing.sv
module dblscan_timing #(
  parameter int H_ACTIVE     = 320,
  parameter int H_FRONT      = 16,
  parameter int H_SYNC       = 32,
  parameter int H_BACK       = 48,
  parameter int V_ACTIVE     = 200,
  parameter int V_FRONT      = 0,
  parameter int V_SYNC       = 2,
  parameter int V_BACK       = 20,
  parameter bit SYNC_ACT_LOW = 1'b1,
  localparam int H_TOTAL = H_ACTIVE + H_FRONT + H_SYNC + H_BACK,
  localparam int V_TOTAL = V_ACTIVE + V_FRONT + V_SYNC + V_BACK,
  localparam int CW      = $clog2(H_TOTAL),
  localparam int RW      = $clog2(V_TOTAL)
) (
  input  logic          clk,
  input  logic          rst,
  output logic          hsync,
  output logic          vsync,
  output logic          de,
  output logic [CW-1:0] col,
  output logic [RW-1:0] row,
  output logic          rescan,
  output logic          frame_end
);
  localparam int H_SYNC_B = H_ACTIVE + H_FRONT;
  localparam int H_SYNC_E = H_SYNC_B + H_SYNC;
  localparam int V_SYNC_B = V_ACTIVE + V_FRONT;
  localparam int V_SYNC_E = V_SYNC_B + V_SYNC;

  logic [CW-1:0] col_n;
  logic [RW-1:0] row_n;
  logic          scan_n, line_last;

  dbs_hcount #(.H_TOTAL(H_TOTAL), .CW(CW)) u_h (
    .clk(clk), .rst(rst), .col_q(col), .col_n(col_n), .line_last(line_last)
  );

  dbs_vcount #(.V_TOTAL(V_TOTAL), .RW(RW)) u_v (
    .clk(clk), .rst(rst), .line_last(line_last),
    .scan_q(rescan), .row_q(row), .scan_n(scan_n), .row_n(row_n)
  );

  dbs_decode #(
    .H_ACTIVE(H_ACTIVE), .H_SYNC_B(H_SYNC_B), .H_SYNC_E(H_SYNC_E), .H_TOTAL(H_TOTAL),
    .V_ACTIVE(V_ACTIVE), .V_SYNC_B(V_SYNC_B), .V_SYNC_E(V_SYNC_E), .V_TOTAL(V_TOTAL),
    .CW(CW), .RW(RW), .ACT_LOW(SYNC_ACT_LOW)
  ) u_d (
    .clk(clk), .col_n(col_n), .row_n(row_n), .scan_n(scan_n),
    .hsync(hsync), .vsync(vsync), .de(de), .frame_end(frame_end)
  );
endmodule

// File: rtl/dblscan_timing_chk.sv
module dblscan_timing_chk #(
  parameter int H_ACTIVE = 320,
  parameter int H_TOTAL  = 416,
  parameter int V_ACTIVE = 200,
  parameter int V_TOTAL  = 222,
  parameter int CW       = 9,
  parameter int RW       = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          hsync,
  input logic          vsync,
  input logic          de,
  input logic [CW-1:0] col,
  input logic [RW-1:0] row,
  input logic          rescan,
  input logic          frame_end
);
  logic at_wrap;
  assign at_wrap = (col == CW'(H_TOTAL - 1));

  p_col_step_r1: assert property (@(posedge clk) disable iff (rst)
    !at_wrap |=> col == $past(col) + 1'b1);
  p_col_wrap_r1: assert property (@(posedge clk) disable iff (rst)
    at_wrap |=> col == '0);
  p_scan_flip_r2: assert property (@(posedge clk) disable iff (rst)
    at_wrap |=> rescan != $past(rescan));
  p_row_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !(at_wrap && rescan) |=> $stable(row));
  p_de_zone_r3: assert property (@(posedge clk) disable iff (rst)
    de |-> (col < CW'(H_ACTIVE)) && (row < RW'(V_ACTIVE)));
  p_fe_single_r6: assert property (@(posedge clk) disable iff (rst)
    frame_end |=> !frame_end);
  p_fe_place_r6: assert property (@(posedge clk) disable iff (rst)
    frame_end |-> at_wrap && rescan && row == RW'(V_TOTAL - 1));
  p_reset_r7: assert property (@(posedge clk)
    rst |=> col == '0 && row == '0 && !rescan && de);
endmodule

bind dblscan_timing dblscan_timing_chk #(
  .H_ACTIVE(H_ACTIVE), .H_TOTAL(H_TOTAL), .V_ACTIVE(V_ACTIVE), .V_TOTAL(V_TOTAL),
  .CW(CW), .RW(RW)
) u_chk (
  .clk(clk), .rst(rst), .hsync(hsync), .vsync(vsync), .de(de), .col(col),
  .row(row), .rescan(rescan), .frame_end(frame_end)
);

// File: tb/dblscan_timing_tb.sv
module dblscan_timing_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       hsync, vsync, de, rescan, frame_end;
  logic [8:0] col;
  logic [7:0] row;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;
  int ec = 0, er = 0, es = 0, fe_seen = 0;

  always #4 clk = ~clk;

  dblscan_timing u_dut (
    .clk(clk), .rst(rst), .hsync(hsync), .vsync(vsync), .de(de),
    .col(col), .row(row), .rescan(rescan), .frame_end(frame_end)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s at col=%0d row=%0d scan=%0d: actual=%0d expected=%0d",
               tag, ec, er, es, act, exp);
    end
  endtask

  task automatic compare_all();
    int e_de, e_hs, e_vs, e_fe;
    e_de = (ec < 320 && er < 200) ? 1 : 0;
    e_hs = (ec >= 336 && ec < 368) ? 0 : 1;
    e_vs = (er >= 200 && er < 202) ? 0 : 1;
    e_fe = (ec == 415 && er == 221 && es == 1) ? 1 : 0;
    chk(int'(col) == ec, "R1 col", int'(col), ec);
    chk(int'(row) == er, "R2 row", int'(row), er);
    chk(int'(rescan) == es, "R2 rescan", int'(rescan), es);
    chk(int'(de) == e_de, "R3 de", int'(de), e_de);
    chk(int'(hsync) == e_hs, "R4 R8 hsync", int'(hsync), e_hs);
    chk(int'(vsync) == e_vs, "R5 R8 vsync", int'(vsync), e_vs);
    chk(int'(frame_end) == e_fe, "R6 frame_end", int'(frame_end), e_fe);
    if (frame_end) fe_seen++;
  endtask

  task automatic step();
    @(posedge clk);
    if (rst) begin
      ec = 0; er = 0; es = 0;
    end else if (ec == 415) begin
      ec = 0;
      if (es == 1) begin
        es = 0;
        er = (er == 221) ? 0 : er + 1;
      end else es = 1;
    end else ec++;
    @(negedge clk);
    compare_all();
  endtask

  initial begin
    repeat (3) step();
    // R7: reset state after reset edges
    chk(col == 9'd0 && row == 8'd0 && !rescan, "R7 counters", int'(col), 0);
    chk(de == 1'b1 && hsync && vsync, "R7 outputs", int'({de, hsync, vsync}), 7);
    rst = 1'b0;
    for (int i = 0; i < 1200; i++) step();
    // R7: mid-frame reset (drive at falling edge)
    rst = 1'b1;
    step();
    chk(col == 9'd0 && row == 8'd0 && !rescan, "R7 mid-frame", int'(col), 0);
    rst = 1'b0;
    fe_seen = 0;
    // full frame: 416 columns x 444 scans; covers R5 zero-porch edge
    for (int i = 0; i < 416 * 444; i++) step();
    chk(fe_seen == 1, "R6 one strobe per frame", fe_seen, 1);
    chk(col == 9'd0 && row == 8'd0 && !rescan, "R2 frame wrap", int'(row), 0);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule